// File: doc/BRIEF.md
# Synchronous Serial Port with Transmit and Receive FIFOs

This block connects a processor to a serial peripheral. The processor pushes bytes through a select/write-strobe bus into a four-entry transmit queue. The transmit engine drains the queue and sends each byte on a single data wire, together with a serial clock that it generates itself, a frame-start pulse and an active-low output enable. The serial clock runs at half the system clock. The receive engine watches an incoming serial clock and frame-start, assembles eight bits into a byte and pushes the byte into a four-entry receive queue. The processor pops that queue with a read strobe.

All logic runs on the system clock and is cleared synchronously. The incoming serial clock is treated as an enable: its rising edges are detected in the system clock domain. A full queue raises its own level interrupt. While a queue is full, further pushes into it are discarded. When the transmit queue already holds the next byte as the current one finishes, frames follow each other with no idle gap. In the intended test set-up the serial outputs are looped back to the serial inputs.

Top module: `sync_serial_port`

## Requirements
- R1: The transmit and receive FIFOs are each DATA_W (8) bits wide and DEPTH (4) entries deep, and they operate independently: one can fill while the other drains.
- R2: `tx_full_irq` is high exactly while the transmit FIFO holds DEPTH bytes, and a write that arrives while it is full is discarded, so that byte is never transmitted.
- R3: `rx_full_irq` is high exactly while the receive FIFO holds DEPTH bytes, and a byte that is received while it is full is dropped.
- R4: `ser_clk_out` toggles on every system clock cycle after clear, which gives half the system rate. The receiver samples `frame_in` and `ser_data_in` on each rising edge of `ser_clk_in`, detected in the system clock domain.
- R5: Each byte is sent most significant bit first, one bit per serial clock period. `ser_data_out` and `frame_out` change only in the cycle in which `ser_clk_out` falls to 0.
- R6: `frame_out` is high for exactly one serial clock period, and that period is the one immediately before the first data bit of a byte.
- R7: `tx_oe_n` is low for exactly the eight bit periods of a lone byte (16 system cycles). While `tx_oe_n` is high, `ser_data_out` is 0.
- R8: If the transmit FIFO is non-empty during the last bit of a byte, the next byte follows with no gap. Its `frame_out` pulse overlaps that last bit, and `tx_oe_n` stays low, so five chained bytes give 80 contiguous low cycles.
- R9: A cycle with `sel`=1 and `wr_en`=1 pushes `wdata` into the transmit FIFO. A cycle with `sel`=1 and `wr_en`=0 pops the receive FIFO into `rdata`, which is visible after the next clock edge.
- R10: A read of an empty receive FIFO leaves `rdata` at its previous value and does not move the FIFO pointers: the next byte received is the next byte read.
- R11: With `clear_n` low at a clock edge, the block goes to idle: `tx_oe_n`=1, and `ser_data_out`, `ser_clk_out`, `frame_out`, both interrupts and `rdata` are all 0.
- R12: A rising `ser_clk_in` with `frame_in`=1 arms the receiver. The next eight rising edges each shift in one bit, most significant first, and the completed byte is pushed into the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Synchronous clear, active low |
| sel | input | 1 | Block select for processor access |
| wr_en | input | 1 | 1 = push to transmit FIFO, 0 = pop receive FIFO |
| wdata | input | DATA_W | Byte written by the processor |
| rdata | output | DATA_W | Last byte popped from the receive FIFO |
| ser_clk_in | input | 1 | Incoming serial clock |
| frame_in | input | 1 | Incoming frame-start |
| ser_data_in | input | 1 | Incoming serial data |
| tx_oe_n | output | 1 | Low while transmit data is valid |
| ser_data_out | output | 1 | Outgoing serial data |
| ser_clk_out | output | 1 | Generated serial clock, half system rate |
| frame_out | output | 1 | Outgoing frame-start pulse |
| tx_full_irq | output | 1 | Transmit FIFO full |
| rx_full_irq | output | 1 | Receive FIFO full |

## Verification
The bound checker checks every cycle that the serial clock alternates and that the FIFO occupancy never goes past DEPTH. It also checks that a push into a full queue leaves the queue's fill level unchanged, that data and frame change only as the serial clock falls, that the data line idles low while the output is disabled, and that each frame pulse lasts a full serial period. Other properties need whole frames and can only be shown by the bench's looped-back scenarios. Those are: most-significant-first byte order, the frame pulse landing just before the first bit, the gap-free chaining of queued bytes, which byte is lost when each queue overflows, and the empty-read hold behaviour.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_LEAD  = 2'd1,
      TX_SHIFT = 2'd2
   } tx_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic [CW-1:0]    level
);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (level == FULL_LVL);
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   // pointer advance: natural wrap for power-of-two depth, compare otherwise
   generate
      if (ssp_pkg::is_pow2(DEPTH)) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!clear_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ssp_tx_engine.sv
module ssp_tx_engine #(
   parameter int WIDTH = 8,
   localparam int NW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             q_empty,
   input  logic [WIDTH-1:0] q_data,
   output logic             q_pop,
   output logic             sclk,
   output logic             sdo,
   output logic             frame,
   output logic             oe_n
);
   import ssp_pkg::*;

   localparam logic [NW-1:0] BIT_LAST = NW'(WIDTH - 1);
   localparam logic [NW-1:0] BIT_PRE  = NW'(WIDTH - 2);

   tx_state_t        st;
   logic [WIDTH-1:0] shreg, hold;
   logic [NW-1:0]    bitn;
   logic             chain;
   logic             boundary;

   // bit boundaries fall on edges where the serial clock goes 1 -> 0
   assign boundary = sclk;
   assign q_pop = boundary && !q_empty &&
                  ((st == TX_IDLE) || (st == TX_SHIFT && bitn == BIT_PRE));

   always_ff @(posedge clk) begin
      if (!clear_n) begin
         st    <= TX_IDLE;
         sclk  <= 1'b0;
         sdo   <= 1'b0;
         frame <= 1'b0;
         oe_n  <= 1'b1;
         shreg <= '0;
         hold  <= '0;
         bitn  <= '0;
         chain <= 1'b0;
      end else begin
         sclk <= ~sclk;
         if (boundary) begin
            unique case (st)
               TX_IDLE: begin
                  if (!q_empty) begin
                     hold  <= q_data;
                     frame <= 1'b1;
                     st    <= TX_LEAD;
                  end
               end
               TX_LEAD: begin
                  frame <= 1'b0;
                  oe_n  <= 1'b0;
                  sdo   <= hold[WIDTH-1];
                  shreg <= hold << 1;
                  bitn  <= '0;
                  st    <= TX_SHIFT;
               end
               TX_SHIFT: begin
                  if (bitn == BIT_LAST) begin
                     if (chain) begin
                        sdo   <= hold[WIDTH-1];
                        shreg <= hold << 1;
                        bitn  <= '0;
                        frame <= 1'b0;
                        chain <= 1'b0;
                     end else begin
                        st   <= TX_IDLE;
                        oe_n <= 1'b1;
                        sdo  <= 1'b0;
                     end
                  end else begin
                     sdo   <= shreg[WIDTH-1];
                     shreg <= shreg << 1;
                     bitn  <= bitn + 1'b1;
                     if (bitn == BIT_PRE && !q_empty) begin
                        hold  <= q_data;
                        frame <= 1'b1;
                        chain <= 1'b1;
                     end
                  end
               end
               default: st <= TX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ssp_rx_engine.sv
module ssp_rx_engine #(
   parameter int WIDTH = 8,
   localparam int NW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             sclk_in,
   input  logic             frame_in,
   input  logic             sdi,
   output logic             push,
   output logic [WIDTH-1:0] word
);
   localparam logic [NW-1:0] BIT_LAST = NW'(WIDTH - 1);

   logic          sclk_d, armed, rise;
   logic [NW-1:0] bitn;

   assign rise = sclk_in && !sclk_d;

   always_ff @(posedge clk) begin
      if (!clear_n) begin
         sclk_d <= 1'b0;
         armed  <= 1'b0;
         bitn   <= '0;
         word   <= '0;
         push   <= 1'b0;
      end else begin
         sclk_d <= sclk_in;
         push   <= 1'b0;
         if (rise) begin
            if (armed) begin
               word <= {word[WIDTH-2:0], sdi};
               if (bitn == BIT_LAST) begin
                  push  <= 1'b1;
                  armed <= 1'b0;
               end else begin
                  bitn <= bitn + 1'b1;
               end
            end
            // a frame marker may share the last bit of the previous byte
            if (frame_in) begin
               armed <= 1'b1;
               bitn  <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              clear_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ser_clk_in,
   input  logic              frame_in,
   input  logic              ser_data_in,
   output logic              tx_oe_n,
   output logic              ser_data_out,
   output logic              ser_clk_out,
   output logic              frame_out,
   output logic              tx_full_irq,
   output logic              rx_full_irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_serial_port: DATA_W must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sync_serial_port: DEPTH must be at least 2");
      end
   endgenerate

   logic              host_push, host_pop;
   logic              tx_empty, tx_pop;
   logic [DATA_W-1:0] tx_head, rx_head, rx_word;
   logic              rx_empty, rx_push;
   logic [CW-1:0]     tx_fill, rx_fill;

   assign host_push = sel && wr_en;
   assign host_pop  = sel && !wr_en;

   ssp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .clear_n(clear_n),
      .push(host_push), .pop(tx_pop), .din(wdata), .dout(tx_head),
      .full(tx_full_irq), .empty(tx_empty), .level(tx_fill)
   );

   ssp_tx_engine #(.WIDTH(DATA_W)) u_tx (
      .clk(clk), .clear_n(clear_n),
      .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
      .sclk(ser_clk_out), .sdo(ser_data_out), .frame(frame_out), .oe_n(tx_oe_n)
   );

   ssp_rx_engine #(.WIDTH(DATA_W)) u_rx (
      .clk(clk), .clear_n(clear_n),
      .sclk_in(ser_clk_in), .frame_in(frame_in), .sdi(ser_data_in),
      .push(rx_push), .word(rx_word)
   );

   ssp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .clear_n(clear_n),
      .push(rx_push), .pop(host_pop), .din(rx_word), .dout(rx_head),
      .full(rx_full_irq), .empty(rx_empty), .level(rx_fill)
   );

   always_ff @(posedge clk) begin
      if (!clear_n)                rdata <= '0;
      else if (host_pop && !rx_empty) rdata <= rx_head;
   end
endmodule

module sync_serial_port_chk #(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          clear_n,
   input logic          sel,
   input logic          wr_en,
   input logic          tx_full_irq,
   input logic          rx_full_irq,
   input logic          tx_oe_n,
   input logic          ser_data_out,
   input logic          ser_clk_out,
   input logic          frame_out,
   input logic [CW-1:0] tx_fill,
   input logic [CW-1:0] rx_fill
);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (tx_fill <= FULL_LVL) && (rx_fill <= FULL_LVL));

   // R2
   tx_drop_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (tx_full_irq && sel && wr_en) |=> (tx_fill <= $past(tx_fill)));

   // R3
   rx_drop_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rx_full_irq && !(sel && !wr_en)) |=> (rx_fill == $past(rx_fill)));

   // R4
   sclk_toggle_chk: assert property (@(posedge clk) disable iff (!clear_n)
      1'b1 |=> (ser_clk_out != $past(ser_clk_out)));

   // R5
   fall_align_chk: assert property (@(posedge clk) disable iff (!clear_n)
      ((ser_data_out != $past(ser_data_out)) || (frame_out != $past(frame_out)))
      |-> !ser_clk_out);

   // R6
   frame_width_chk: assert property (@(posedge clk) disable iff (!clear_n)
      $rose(frame_out) |=> frame_out);

   // R7
   idle_low_chk: assert property (@(posedge clk) disable iff (!clear_n)
      tx_oe_n |-> !ser_data_out);
endmodule

bind sync_serial_port sync_serial_port_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .clear_n(clear_n), .sel(sel), .wr_en(wr_en),
   .tx_full_irq(tx_full_irq), .rx_full_irq(rx_full_irq),
   .tx_oe_n(tx_oe_n), .ser_data_out(ser_data_out),
   .ser_clk_out(ser_clk_out), .frame_out(frame_out),
   .tx_fill(tx_fill), .rx_fill(rx_fill)
);

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
   logic       clk = 1'b0;
   logic       clear_n = 1'b0;
   logic       sel = 1'b0, wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tx_oe_n, ser_data_out, ser_clk_out, frame_out;
   logic       tx_full_irq, rx_full_irq;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   logic [7:0] tx_expect[$];
   int         bytes_seen = 0;
   int         last_run = 0;

   always #4 clk = ~clk;

   // external loopback
   sync_serial_port u_sync_serial_port (
      .clk(clk), .clear_n(clear_n), .sel(sel), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata),
      .ser_clk_in(ser_clk_out), .frame_in(frame_out), .ser_data_in(ser_data_out),
      .tx_oe_n(tx_oe_n), .ser_data_out(ser_data_out), .ser_clk_out(ser_clk_out),
      .frame_out(frame_out), .tx_full_irq(tx_full_irq), .rx_full_irq(rx_full_irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input bit expect_out);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; wdata = b;
      if (expect_out) tx_expect.push_back(b);
   endtask

   task automatic idle_bus();
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
   endtask

   task automatic fetch(output logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b0;
      @(negedge clk);
      sel = 1'b0;
      v = rdata;
   endtask

   // serial monitor: scoreboard consumer
   initial begin : monitor
      logic       prev_sclk = 1'b0;
      logic       frame_at_rise = 1'b0;
      logic       prev_oe = 1'b1;
      logic [7:0] shreg = '0;
      int         nbits = 0;
      int         run = 0;
      forever begin
         @(negedge clk);
         if (clear_n) begin
            if (!tx_oe_n) run++;
            if (tx_oe_n && !prev_oe) begin last_run = run; run = 0; end
            prev_oe = tx_oe_n;
            if (ser_clk_out && !prev_sclk) begin
               if (!tx_oe_n) begin
                  // R6: frame seen on the serial period before the first bit
                  if (nbits == 0) check(frame_at_rise == 1'b1, "R6", frame_at_rise, 1);
                  shreg = {shreg[6:0], ser_data_out};
                  nbits++;
                  if (nbits == 8) begin
                     bytes_seen++;
                     if (tx_expect.size() == 0) begin
                        check(1'b0, "R5", shreg, 0);
                     end else begin
                        logic [7:0] e;
                        e = tx_expect.pop_front();
                        // R5: MSB-first byte order on the wire
                        check(shreg == e, "R5", shreg, e);
                     end
                     nbits = 0;
                  end
               end
               frame_at_rise = frame_out;
            end
            prev_sclk = ser_clk_out;
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : stimulus
      logic [7:0] v;
      logic [7:0] burst [6] = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h5A, 8'hC3};
      int toggles;
      logic last;

      repeat (4) @(negedge clk);
      // R11: idle state under clear
      check(tx_oe_n == 1'b1, "R11", tx_oe_n, 1);
      check(ser_data_out == 1'b0, "R11", ser_data_out, 0);
      check(ser_clk_out == 1'b0, "R11", ser_clk_out, 0);
      check(frame_out == 1'b0, "R11", frame_out, 0);
      check({tx_full_irq, rx_full_irq} == 2'b00, "R11", {tx_full_irq, rx_full_irq}, 0);
      check(rdata == 8'h00, "R11", rdata, 0);
      clear_n = 1'b1;

      // R4: serial clock alternates every system cycle
      toggles = 0;
      @(negedge clk); last = ser_clk_out;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ser_clk_out != last) toggles++;
         last = ser_clk_out;
      end
      check(toggles == 10, "R4", toggles, 10);

      // single byte
      send(8'hA5, 1'b1);
      idle_bus();
      repeat (50) @(negedge clk);
      check(last_run == 16, "R7", last_run, 16);
      fetch(v);
      check(v == 8'hA5, "R9 R12", v, 8'hA5);

      // burst of six: the sixth finds the queue full (R2)
      for (int i = 0; i < 6; i++) send(burst[i], i < 5);
      idle_bus();
      check(tx_full_irq == 1'b1, "R2", tx_full_irq, 1);
      repeat (150) @(negedge clk);
      check(tx_full_irq == 1'b0, "R2", tx_full_irq, 0);
      check(last_run == 80, "R8", last_run, 80);
      check(bytes_seen == 6, "R2", bytes_seen, 6);
      check(tx_expect.size() == 0, "R8", tx_expect.size(), 0);
      // R3: fifth received byte dropped while receive queue full
      check(rx_full_irq == 1'b1, "R3", rx_full_irq, 1);
      for (int i = 0; i < 4; i++) begin
         fetch(v);
         check(v == burst[i], "R1 R3", v, burst[i]);
      end
      check(rx_full_irq == 1'b0, "R3", rx_full_irq, 0);

      // R10: empty read holds value and keeps order
      fetch(v);
      check(v == 8'h00, "R10", v, 8'h00);
      send(8'h96, 1'b1);
      idle_bus();
      repeat (50) @(negedge clk);
      fetch(v);
      check(v == 8'h96, "R10", v, 8'h96);
      check(bytes_seen == 7, "R12", bytes_seen, 7);

      summary();
   end
endmodule